// File: doc/BRIEF.md
# Pin-Routed Edge Counter and Phase Oscillator

This block is one timer channel for a fabric with 32 general-purpose pins. A control word chooses an operating mode and routes two pins to the channel: an input pin for counting and an output pin for waveform generation. Each routing choice is a 5-bit pin index, and the two choices are independent, so any pin can fill either role. The channel also holds an addend register and a 32-bit phase register.

In the two counting modes, the selected input pin passes through a two-flop synchroniser and then a current/previous flop pair. The pair produces one single-clock pulse per qualifying transition, either rising or falling. Each pulse adds the addend to the phase register, so an addend of 1 gives a plain transition count.

In oscillator mode, the addend is added on every clock. The top bit of the phase register drives the selected output pin, and that pin's output enable is raised. Software loads and reads all three registers over a single-cycle synchronous bus whose read data is combinational.

Top module: `pin_edge_nco`

## Requirements
- R1: After reset, the control, addend and phase registers read zero, and pins_out and pins_oe are all zero.
- R2: Register addresses are: 0 for control, 1 for addend, 2 for phase; address 3 reads zero. The control layout is mode in bits [1:0], input pin index in bits [12:8] and output pin index in bits [20:16]. All other control bits read back as zero.
- R3: In mode 1, the phase register gains the addend exactly once for each low-to-high transition of the selected input pin.
- R4: In mode 2, the phase register gains the addend exactly once for each high-to-low transition of the selected input pin.
- R5: An input that is high for one clock and low for one clock is counted once per period, with no transition lost.
- R6: In mode 0, the phase register holds its value whatever the pins do, and pins_out and pins_oe are all zero.
- R7: In mode 3, the phase register gains the addend on every clock. pins_oe has exactly the bit of the output pin index set, and that bit of pins_out equals phase bit 31. In every mode other than 3, pins_oe is zero.
- R8: In mode 3 with addend 0x8000_0000, the output pin changes level on every clock.
- R9: A bus write to the phase register loads the written value on that clock and overrides any add on the same clock.
- R10: An input transition first sampled at clock edge n shows in the phase register after edge n+3 and not before.
- R11: In mode 3 with addend 0x5555_5556, the output has no high run and no low run longer than two clocks. Over 300 clocks it has 100 rising edges, give or take one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_in | input | 32 | Sampled levels of all pins |
| pins_out | output | 32 | Drive levels onto pins |
| pins_oe | output | 32 | Per-pin output enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |

## Verification
A dropped or duplicated transition in the synchroniser or decode flops leaves a permanent error in the phase register. That error shows on the next phase read, three clocks after the transition is sampled. A bad oscillator step shows one clock later, either in the phase read or as a wrong level on the routed pin. The bench compares the phase register and both pin vectors against a bench-side model every cycle, so a fault is reported within a few clocks of where it arises.

// File: rtl/pin_edge_nco.sv
module pin_edge_nco #(
  parameter int NPIN        = 32,
  parameter int ACC_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPIN-1:0]  pins_in,
  output logic [NPIN-1:0]  pins_out,
  output logic [NPIN-1:0]  pins_oe,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [ACC_W-1:0] bus_wdata,
  output logic [ACC_W-1:0] bus_rdata
);
  localparam int SEL_W   = $clog2(NPIN);
  localparam int SELA_LO = 8;
  localparam int SELB_LO = 16;

  localparam logic [1:0] M_OFF  = 2'd0;
  localparam logic [1:0] M_RISE = 2'd1;
  localparam logic [1:0] M_FALL = 2'd2;
  localparam logic [1:0] M_NCO  = 2'd3;

  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_ADD   = 2'd1;
  localparam logic [1:0] A_PHASE = 2'd2;

  logic [1:0]             mode_q;
  logic [SEL_W-1:0]       sel_a_q, sel_b_q;
  logic [ACC_W-1:0]       addend_q, acc_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   cur_q, prev_q;
  logic                   rise, fall, step;
  logic [ACC_W-1:0]       ctrl_rd;

  assign rise = cur_q & ~prev_q;
  assign fall = ~cur_q & prev_q;

  always_comb begin
    case (mode_q)
      M_RISE:  step = rise;
      M_FALL:  step = fall;
      M_NCO:   step = 1'b1;
      default: step = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      cur_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pins_in[sel_a_q]};
      cur_q  <= sync_q[SYNC_STAGES-1];
      prev_q <= cur_q;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= M_OFF;
      sel_a_q  <= '0;
      sel_b_q  <= '0;
      addend_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_CTRL) begin
        mode_q  <= bus_wdata[1:0];
        sel_a_q <= bus_wdata[SELA_LO +: SEL_W];
        sel_b_q <= bus_wdata[SELB_LO +: SEL_W];
      end
      if (bus_addr == A_ADD) addend_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                             acc_q <= '0;
    else if (bus_wr && bus_addr == A_PHASE) acc_q <= bus_wdata;
    else if (step)                          acc_q <= acc_q + addend_q;
  end

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[1:0] = mode_q;
    ctrl_rd[SELA_LO +: SEL_W] = sel_a_q;
    ctrl_rd[SELB_LO +: SEL_W] = sel_b_q;
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl_rd;
      A_ADD:   bus_rdata = addend_q;
      A_PHASE: bus_rdata = acc_q;
      default: bus_rdata = '0;
    endcase
  end

  assign pins_oe  = (mode_q == M_NCO) ? (NPIN'(1) << sel_b_q) : '0;
  assign pins_out = (mode_q == M_NCO) ? (NPIN'(acc_q[ACC_W-1]) << sel_b_q) : '0;
endmodule

// File: rtl/pin_edge_nco_chk.sv
module pin_edge_nco_chk #(
  parameter int NPIN  = 32,
  parameter int ACC_W = 32,
  parameter int SEL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_q,
  input logic [SEL_W-1:0] sel_b_q,
  input logic [ACC_W-1:0] acc_q,
  input logic [ACC_W-1:0] addend_q,
  input logic             bus_wr,
  input logic [1:0]       bus_addr,
  input logic [ACC_W-1:0] bus_wdata,
  input logic [NPIN-1:0]  pins_out,
  input logic [NPIN-1:0]  pins_oe
);
  logic ph_wr;
  assign ph_wr = bus_wr && bus_addr == 2'd2;

  // R6
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd0 && !ph_wr) |=> acc_q == $past(acc_q));

  // R7
  oe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pins_oe) && ((pins_out & ~pins_oe) == '0));

  // R7
  nco_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd3) |-> (pins_oe[sel_b_q] && pins_out[sel_b_q] == acc_q[ACC_W-1]));

  // R7
  nco_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd3 && !ph_wr) |=> acc_q == $past(acc_q) + $past(addend_q));

  // R3
  edge_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode_q == 2'd1 || mode_q == 2'd2) && !ph_wr)
      |=> (acc_q == $past(acc_q) || acc_q == $past(acc_q) + $past(addend_q)));

  // R9
  phase_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph_wr |=> acc_q == $past(bus_wdata));
endmodule

bind pin_edge_nco pin_edge_nco_chk #(.NPIN(NPIN), .ACC_W(ACC_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .sel_b_q(sel_b_q), .acc_q(acc_q),
  .addend_q(addend_q), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .pins_out(pins_out), .pins_oe(pins_oe)
);

// File: tb/pin_edge_nco_tb.sv
module pin_edge_nco_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins_in = '0;
  logic [31:0] pins_out, pins_oe;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd2;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int fails  = 0;
  bit mon_en = 1'b0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pin_edge_nco u_dut (
    .clk(clk), .rst_n(rst_n), .pins_in(pins_in), .pins_out(pins_out), .pins_oe(pins_oe),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  logic [1:0]  m_mode;
  logic [4:0]  m_sela, m_selb;
  logic [31:0] m_add, m_phase;
  logic [3:0]  m_hist;

  function automatic logic [31:0] ctrl_word(input logic [1:0] md, input logic [4:0] a, input logic [4:0] b);
    return {11'd0, b, 3'd0, a, 6'd0, md};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode <= '0; m_sela <= '0; m_selb <= '0; m_add <= '0; m_phase <= '0; m_hist <= '0;
    end else begin
      m_hist <= {m_hist[2:0], pins_in[m_sela]};
      if (bus_wr && bus_addr == 2'd2) m_phase <= bus_wdata;
      else if ((m_mode == 2'd1 && m_hist[2] && !m_hist[3]) ||
               (m_mode == 2'd2 && !m_hist[2] && m_hist[3]) ||
               (m_mode == 2'd3))
        m_phase <= m_phase + m_add;
      if (bus_wr && bus_addr == 2'd0) begin
        m_mode <= bus_wdata[1:0]; m_sela <= bus_wdata[12:8]; m_selb <= bus_wdata[20:16];
      end
      if (bus_wr && bus_addr == 2'd1) m_add <= bus_wdata;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (mon_en && !bus_wr && bus_addr == 2'd2) begin
      check(m_mode == 2'd3 ? "R7 phase" : m_mode == 2'd0 ? "R6 phase" :
            m_mode == 2'd1 ? "R3 phase" : "R4 phase", bus_rdata, m_phase);
      if (m_mode == 2'd3) begin
        check("R7 oe", pins_oe, 32'd1 << m_selb);
        check("R7 out", pins_out, {31'd0, m_phase[31]} << m_selb);
      end else begin
        check("R6 oe", pins_oe, 32'd0);
        check("R6 out", pins_out, 32'd0);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 2'd2;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_addr = 2'd2;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic random_run(input logic [4:0] sel, input int cycles, input int maxhold);
    int hold = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (hold == 0) begin
        pins_in[sel] = ~pins_in[sel];
        hold = $urandom_range(maxhold - 1, 0);
      end else hold--;
      for (int p = 0; p < 32; p++) if (p != sel) pins_in[p] = $urandom_range(1, 0);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic        last;
    int          rises, run_hi, run_lo, max_hi, max_lo;
    void'($urandom(32'h5eed_0042));
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 phase", bus_rdata, 32'd0);
    check("R1 oe", pins_oe, 32'd0);
    check("R1 out", pins_out, 32'd0);
    rd(2'd0, v); check("R1 ctrl", v, 32'd0);
    rd(2'd1, v); check("R1 addend", v, 32'd0);

    // R2 layout and readback
    wr(2'd0, 32'hFFFF_FFFC);
    rd(2'd0, v); check("R2 ctrl mask", v, 32'h001F_1F00);
    wr(2'd1, 32'hA5A5_1234);
    rd(2'd1, v); check("R2 addend", v, 32'hA5A5_1234);
    rd(2'd3, v); check("R2 addr3", v, 32'd0);
    mon_en = 1'b1;

    // R10 latency
    wr(2'd1, 32'd1);
    wr(2'd0, ctrl_word(2'd1, 5'd7, 5'd0));
    wr(2'd2, 32'd0);
    idle(6);
    pins_in[7] = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      check("R10 latency", bus_rdata, (i < 3) ? 32'd0 : 32'd1);
    end
    @(negedge clk) pins_in[7] = 1'b0;
    idle(6);

    // R5 half-rate input
    wr(2'd2, 32'd0);
    for (int i = 0; i < 200; i++) @(negedge clk) pins_in[7] = (i % 2 == 0);
    @(negedge clk) pins_in[7] = 1'b0;
    idle(6); #1;
    check("R5 half rate count", bus_rdata, 32'd100);

    // R3 rising mode, random addend and rates
    wr(2'd1, $urandom);
    wr(2'd0, ctrl_word(2'd1, 5'd19, 5'd3));
    random_run(5'd19, 400, 6);
    random_run(5'd19, 100, 1);

    // R4 falling mode, uneven duties
    wr(2'd1, $urandom);
    wr(2'd0, ctrl_word(2'd2, 5'd0, 5'd3));
    random_run(5'd0, 400, 5);
    random_run(5'd0, 200, 2);
    idle(5); #1;
    check("R4 final phase", bus_rdata, m_phase);

    // R6 disabled channel holds
    wr(2'd2, 32'h0000_1234);
    wr(2'd0, ctrl_word(2'd0, 5'd0, 5'd9));
    random_run(5'd0, 60, 2);
    idle(1); #1;
    check("R6 hold", bus_rdata, 32'h0000_1234);

    // R7 oscillator, random addend
    wr(2'd1, $urandom);
    wr(2'd0, ctrl_word(2'd3, 5'd0, 5'd21));
    random_run(5'd0, 300, 4);

    // R9 phase write wins over add
    wr(2'd2, 32'hDEAD_0000);
    #1 check("R9 load", bus_rdata, 32'hDEAD_0000);

    // R8 half-rate oscillator
    wr(2'd1, 32'h8000_0000);
    wr(2'd0, ctrl_word(2'd3, 5'd0, 5'd5));
    @(negedge clk); #1 last = pins_out[5];
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1;
      check("R8 toggle", {31'd0, pins_out[5]}, {31'd0, ~last});
      last = pins_out[5];
    end

    // R11 divide by three
    wr(2'd1, 32'h5555_5556);
    wr(2'd0, ctrl_word(2'd3, 5'd0, 5'd30));
    @(negedge clk); #1 last = pins_out[30];
    rises = 0; run_hi = 0; run_lo = 0; max_hi = 0; max_lo = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); #1;
      if (pins_out[30] && !last) rises++;
      if (pins_out[30]) begin run_hi++; run_lo = 0; end else begin run_lo++; run_hi = 0; end
      if (run_hi > max_hi) max_hi = run_hi;
      if (run_lo > max_lo) max_lo = run_lo;
      last = pins_out[30];
    end
    check("R11 high run", (max_hi <= 2) ? 32'd1 : 32'd0, 32'd1);
    check("R11 low run", (max_lo <= 2) ? 32'd1 : 32'd0, 32'd1);
    check("R11 rate", (rises >= 99 && rises <= 101) ? 32'd1 : 32'd0, 32'd1);

    // R6 outputs released again
    wr(2'd0, ctrl_word(2'd0, 5'd0, 5'd30));
    idle(2); #1;
    check("R6 released", pins_oe, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule